// File: doc/BRIEF.md
# GPIO Edge-Triggered Interrupt Generator

This block watches a bank-organised set of general-purpose inputs and produces an interrupt pulse and a DMA event pulse whenever an input makes a transition the software has asked for. Each pin has two sensitivity bits. One arms it for low-to-high transitions and the other for high-to-low transitions. Either, both or neither may be set.

The two sensitivity registers cannot be written directly. Software changes them through four alias addresses: one set and one clear for each register. A 1 in a written bit acts on that pin and a 0 leaves it alone. Reads of either alias of a register return that register's current contents.

Pins are grouped in banks of 16. Each bank has its own enable bit, and that bit gates the bank's combined outputs. Inputs pass through a two-flop synchronizer before edge detection, and the outputs come from registers.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rising-sensitivity register, the falling-sensitivity register and the bank-enable register all read as zero, and `irq_o` and `dma_o` are low.
- R2: A pin whose rising and falling bits are both 0 produces no pulse on either output, whatever its input does.
- R3: A pin with only its falling bit set produces a pulse on a 1-to-0 input change and none on a 0-to-1 change.
- R4: A pin with only its rising bit set produces a pulse on a 0-to-1 input change and none on a 1-to-0 change.
- R5: A pin with both bits set produces a pulse on every input change.
- R6: A write to address 1 sets the rising bits where the written data is 1, and a write to address 3 does the same for the falling bits. Bits written as 0 keep their value.
- R7: A write to address 2 clears the rising bits where the written data is 1, and a write to address 4 does the same for the falling bits. Bits written as 0 keep their value.
- R8: `rdata_o` returns the rising register when `addr_i` is 1 or 2 and the falling register when `addr_i` is 4 or 3. It returns the bank-enable register, zero-extended, at address 0.
- R9: Bank-enable bit b is written and read at address 0 from data bit b. Pins 16b to 16b+15 reach output bit b only while that enable bit is 1.
- R10: An input change sampled at clock edge k produces a one-cycle high on `irq_o` and `dma_o` after edge k+2, and both outputs are always identical.
- R11: Output bit b is the OR of the qualifying pulses of all pins in bank b, so changes on several pins in the same cycle give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous general-purpose inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (0 enable, 1 set-rise, 2 clear-rise, 3 set-fall, 4 clear-fall) |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data for `addr_i` (combinational) |
| irq_o | output | NUM_BANKS | Per-bank interrupt pulse |
| dma_o | output | NUM_BANKS | Per-bank DMA event pulse |

## Verification
The bench arms one pin for each sensitivity mode and toggles it. A design with swapped or inverted edge polarity pulses on the wrong transition, or pulses twice where it should pulse once. It reads every alias after set and clear writes that include 0 bits. A design whose clear writes zeros over unselected bits, or whose aliases return the wrong register, shows a readback mismatch. It toggles pins in a disabled bank and toggles several pins of one bank together. Missing gating leaks pulses from the disabled bank, and a per-pin count instead of an OR produces extra pulses. A per-clock reference compare catches any shift in latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_BANK_EN  = 3'd0,
    A_SET_RISE = 3'd1,
    A_CLR_RISE = 3'd2,
    A_SET_FALL = 3'd3,
    A_CLR_FALL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= lvl_i;
  end

  assign hit_o = (lvl_i & ~last_q & rise_en_i) | (~lvl_i & last_q & fall_en_i);
endmodule

// File: rtl/gpio_trig_regs.sv
module gpio_trig_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PINS-1:0]  wdata_i,
  output logic [NUM_PINS-1:0]  rise_o,
  output logic [NUM_PINS-1:0]  fall_o,
  output logic [NUM_BANKS-1:0] bank_en_o
);
  logic [NUM_PINS-1:0] rise_set, rise_clr, fall_set, fall_clr;
  logic [NUM_PINS-1:0] rise_q, fall_q;
  logic [NUM_BANKS-1:0] en_q;

  always_comb begin
    rise_set = '0;
    rise_clr = '0;
    fall_set = '0;
    fall_clr = '0;
    if (wr_en_i) begin
      unique case (reg_addr_e'(addr_i))
        A_SET_RISE: rise_set = wdata_i;
        A_CLR_RISE: rise_clr = wdata_i;
        A_SET_FALL: fall_set = wdata_i;
        A_CLR_FALL: fall_clr = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= '0;
    end else begin
      // set applied last so it wins over a clear of the same bit
      rise_q <= (rise_q & ~rise_clr) | rise_set;
      fall_q <= (fall_q & ~fall_clr) | fall_set;
      if (wr_en_i && reg_addr_e'(addr_i) == A_BANK_EN) en_q <= wdata_i[NUM_BANKS-1:0];
    end
  end

  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign bank_en_o = en_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned BANK_PINS = 16,
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PINS-1:0]  wdata_i,
  output logic [NUM_PINS-1:0]  rdata_o,
  output logic [NUM_BANKS-1:0] irq_o,
  output logic [NUM_BANKS-1:0] dma_o
);
  logic [NUM_PINS-1:0]  lvl, hit, rise_q, fall_q;
  logic [NUM_BANKS-1:0] bank_en_q, bank_hit, irq_q, dma_q;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  gpio_trig_regs #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rise_o(rise_q), .fall_o(fall_q), .bank_en_o(bank_en_q)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
    .rise_en_i(rise_q), .fall_en_i(fall_q), .hit_o(hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_PINS;
    localparam int unsigned HI = (LO + BANK_PINS > NUM_PINS) ? NUM_PINS - 1 : LO + BANK_PINS - 1;
    assign bank_hit[b] = |hit[HI:LO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      dma_q <= '0;
    end else begin
      irq_q <= bank_hit & bank_en_q;
      dma_q <= bank_hit & bank_en_q;
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_BANK_EN:              rdata_o = NUM_PINS'(bank_en_q);
      A_SET_RISE, A_CLR_RISE: rdata_o = rise_q;
      A_SET_FALL, A_CLR_FALL: rdata_o = fall_q;
      default:                rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_BANKS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_PINS-1:0]  wdata_i,
  input logic [NUM_PINS-1:0]  rise_q,
  input logic [NUM_PINS-1:0]  fall_q,
  input logic [NUM_BANKS-1:0] bank_en_q,
  input logic [NUM_BANKS-1:0] irq_o,
  input logic [NUM_BANKS-1:0] dma_o
);
  AST_IRQ_DMA_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == dma_o); // R10

  AST_NO_TRIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q == '0 && fall_q == '0) |=> (irq_o == '0)); // R2

  AST_SET_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SET_RISE) |=> ((rise_q & $past(wdata_i)) == $past(wdata_i))); // R6

  AST_CLR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CLR_FALL) |=> ((fall_q & $past(wdata_i)) == '0)); // R7

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_BANK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bank_en_q[b] |=> !irq_o[b]); // R9
  end
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rise_q(rise_q), .fall_q(fall_q), .bank_en_q(bank_en_q), .irq_o(irq_o), .dma_o(dma_o)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  localparam int NP = 32;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic [NB-1:0] irq, dma;

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R1";

  // reference model state
  logic [NP-1:0] m_rise, m_fall;
  logic [NB-1:0] m_en, exp_irq;
  logic [NP-1:0] hist[$];

  always #2 clk = ~clk;

  gpio_edge_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .dma_o(dma)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rise = '0; m_fall = '0; m_en = '0; exp_irq = '0;
      hist = '{'0, '0, '0};
    end else begin
      logic [NB-1:0] e;
      e = '0;
      for (int p = 0; p < NP; p++) begin
        logic nw, od;
        nw = hist[1][p];
        od = hist[2][p];
        if ((nw && !od && m_rise[p]) || (!nw && od && m_fall[p])) e[p/16] = 1'b1;
      end
      exp_irq = e & m_en;
      if (wr_en) begin
        case (addr)
          3'd0: m_en = wdata[NB-1:0];
          3'd1: m_rise = m_rise | wdata;
          3'd2: m_rise = m_rise & ~wdata;
          3'd3: m_fall = m_fall | wdata;
          3'd4: m_fall = m_fall & ~wdata;
          default: ;
        endcase
      end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  // per-clock output compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (irq !== exp_irq || dma !== exp_irq) begin
        n_err++;
        $display("FAIL %s irq=%b dma=%b expected=%b at %0t", cur_tag, irq, dma, exp_irq, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [NP-1:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic drive(input logic [NP-1:0] v, input int settle);
    @(negedge clk);
    pin = v;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset contents
    chk("R1 irq", NP'(irq), '0);
    chk("R1 dma", NP'(dma), '0);
    rst_n = 1'b1;
    rd("R1 en", 3'd0, '0);
    rd("R1 rise", 3'd1, '0);
    rd("R1 fall", 3'd3, '0);

    // R9: enable both banks, read back
    wr(3'd0, 32'h3);
    rd("R9 en readback", 3'd0, 32'h3);

    // R2: unarmed pins stay silent
    cur_tag = "R2";
    drive(32'h0000_0001, 5);
    drive(32'h0000_0000, 5);
    chk("R2 no pulse", NP'(irq), '0);

    // R6, R8: set aliases, zero bits keep value
    wr(3'd1, 32'h0002_0001);
    wr(3'd1, 32'h0000_0100);
    rd("R6 set rise", 3'd1, 32'h0002_0101);
    rd("R8 rise via clr alias", 3'd2, 32'h0002_0101);
    wr(3'd3, 32'h0000_0021);
    rd("R6 set fall", 3'd3, 32'h0000_0021);
    rd("R8 fall via clr alias", 3'd4, 32'h0000_0021);

    // R10: exact latency on pin 8 (rise only)
    cur_tag = "R10";
    @(negedge clk);
    pin = 32'h0000_0100;
    @(negedge clk); chk("R10 edge1", NP'(irq), '0);
    @(negedge clk); chk("R10 edge2", NP'(irq), '0);
    @(negedge clk); chk("R10 edge3", NP'(irq), 32'h1);
    @(negedge clk); chk("R10 edge4", NP'(irq), '0);

    // R4: rise-only pin 8 ignores falling edge
    cur_tag = "R4";
    drive(32'h0000_0000, 6);
    // R3: fall-only pin 5
    cur_tag = "R3";
    drive(32'h0000_0020, 6);
    drive(32'h0000_0000, 6);
    // R5: pin 0 armed for both
    cur_tag = "R5";
    drive(32'h0000_0001, 6);
    drive(32'h0000_0000, 6);
    // R4: bank 1 pin 17 rising
    cur_tag = "R4";
    drive(32'h0002_0000, 6);
    drive(32'h0000_0000, 6);

    // R11: several pins in one bank at once
    cur_tag = "R11";
    drive(32'h0000_0121, 6);
    drive(32'h0000_0000, 6);
    drive(32'h0002_0001, 6);
    drive(32'h0000_0000, 6);

    // R7: clear aliases, zero bits keep value
    wr(3'd2, 32'h0000_0001);
    rd("R7 clr rise", 3'd1, 32'h0002_0100);
    wr(3'd4, 32'h0000_0020);
    rd("R7 clr fall", 3'd4, 32'h0000_0001);
    cur_tag = "R7";
    drive(32'h0000_0001, 6);
    drive(32'h0000_0000, 6);

    // R9: disable bank 1, pin 17 must not leak
    wr(3'd0, 32'h1);
    rd("R9 en readback", 3'd0, 32'h1);
    cur_tag = "R9";
    drive(32'h0002_0000, 6);
    chk("R9 bank1 quiet", NP'(irq), '0);
    drive(32'h0002_0100, 3);
    chk("R9 bank0 live", NP'(irq), 32'h1);
    drive(32'h0000_0000, 6);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule